// File: doc/BRIEF.md
# Battery Swap and Start-up Sequencer

This block decides when the fuel-gauge core starts, when it must start over, and what the platform sees while the first battery reading is taken. After power-on or a soft reset it waits out a fixed settling interval. It then requests one open-circuit voltage measurement. While that measurement is in flight it drives the charger-disable output high. If the platform reset line was already being held low, it keeps that line pulled low until the measurement completes, so that neither charging current nor application start-up disturbs the reading.

All timing is counted in pulses of a 32768 Hz enable, `tick`. The block watches two comparator outputs: one reports the supply below its lockout level, the other reports a battery-detect pin above its threshold. A short excursion on either one is ignored. An excursion that lasts for the full qualification window counts as a battery swap. On a swap the block sets a sticky failure flag, parks until the offending input returns to its good level, then emits a one-cycle restart pulse and runs the whole start-up sequence again. A power-on flag reads 1 after reset, and software uses the same flag to request a soft reset.

Top module: `bswap_seq`

## Requirements
- R1: While `rst_n` is low and directly after it: `por_flag`=1, `fail_flag`=0, `meas_req`=0, `chg_inhibit`=0, `restart`=0, and `rst_pulldown`=0 when the sensed line is high.
- R2: `meas_req` rises after exactly DEBOUNCE_TICKS clock edges with `tick`=1, counted from reset release, a soft reset or a restart. Edges with `tick`=0 do not advance the count.
- R3: `meas_req` and `chg_inhibit` are both 1 throughout the measurement state and both fall one edge after `meas_done`. A `meas_done` outside the measurement state has no effect.
- R4: If `rst_sense` is 0 in any cycle of settling or measurement, `rst_pulldown` goes to 1 on the next edge and stays 1 until the edge that accepts `meas_done`. If the line stays high, `rst_pulldown` stays 0.
- R5: `uv_low`=1 for QUAL_TICKS consecutive ticked edges is a swap, and `fail_flag` is 1 one edge later. A return to 0 before then resets the count, so a shorter dip (or two dips split by one good cycle) changes nothing.
- R6: After a supply swap, the first edge with `uv_low`=0 produces `restart`=1 for exactly one cycle and re-enters settling.
- R7: `det_high`=1 for QUAL_TICKS ticked edges is also a swap. The restart follows the first edge with `det_high`=0.
- R8: `fail_wr` with `fail_wdata`=0 clears `fail_flag`, and `fail_wdata`=1 leaves it unchanged. A swap set wins over a clear in the same cycle.
- R9: `por_wr` with `por_wdata`=1 is a soft reset. It re-enters settling without a restart pulse, clears `fail_flag` and sets `por_flag`. `por_wr` with `por_wdata`=0 clears `por_flag`.
- R10: When a qualified swap and `meas_done` arrive in the same cycle, the swap wins: the block enters the swap state, and the restart follows once the input recovers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 32768 Hz time-base enable, one clock wide |
| uv_low | input | 1 | Supply below lockout level |
| det_high | input | 1 | Battery-detect pin above threshold (battery absent) |
| rst_sense | input | 1 | Sensed level of the platform reset line |
| meas_done | input | 1 | Strobe: requested measurement finished |
| fail_wr | input | 1 | Write strobe for the failure flag |
| fail_wdata | input | 1 | Data for the failure-flag write |
| por_wr | input | 1 | Write strobe for the power-on flag |
| por_wdata | input | 1 | Data for the power-on flag write (1 = soft reset) |
| chg_inhibit | output | 1 | Drive-high request for the charger disable pin |
| rst_pulldown | output | 1 | Pull-down enable for the platform reset line |
| meas_req | output | 1 | First open-circuit measurement request |
| restart | output | 1 | One-cycle pulse when a swap restart begins |
| fail_flag | output | 1 | Sticky swap/undervoltage flag |
| por_flag | output | 1 | Power-on / soft-reset detection flag |

## Verification
Two pairs of functions can land in the same cycle. A swap can qualify on the edge that also carries `meas_done`. A swap can also set the failure flag on the edge where software writes it to 0. The bench holds `uv_low` for exactly the qualification length and places the competing strobe one edge after the last counted tick. That edge is where the registered qualifier output is consumed. The bench judges the swap as winner when the flag is still 1 and, for the measurement case, when a restart pulse appears after `uv_low` drops; a clean end of measurement would produce no such pulse.

// File: rtl/bswap_pkg.sv
package bswap_pkg;
   typedef enum logic [2:0] {
      ST_SETTLE   = 3'd0,
      ST_MEASURE  = 3'd1,
      ST_RUN      = 3'd2,
      ST_SWAP_UV  = 3'd3,
      ST_SWAP_DET = 3'd4
   } seq_state_t;

   localparam int NUM_SRC = 2;
   localparam int SRC_UV  = 0;   // higher priority when both qualify together
   localparam int SRC_DET = 1;
endpackage

// File: rtl/bswap_qualify.sv
module bswap_qualify #(
   parameter int QUAL_TICKS = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic tick,
   input  logic bad,
   output logic fire
);
   localparam int QW = $clog2(QUAL_TICKS + 1);
   localparam logic [QW-1:0] QMAX = QW'(QUAL_TICKS);
   localparam logic [QW-1:0] QLAST = QW'(QUAL_TICKS - 1);

   logic [QW-1:0] cnt;

   if (QUAL_TICKS < 2) begin : g_bad_qual
      $error("bswap_qualify: QUAL_TICKS must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         fire <= 1'b0;
      end else begin
         fire <= 1'b0;
         if (clear || !bad) begin
            cnt <= '0;
         end else if (tick && (cnt < QMAX)) begin
            cnt <= cnt + 1'b1;
            if (cnt == QLAST) fire <= 1'b1;
         end
      end
   end

   // R5: saturation keeps the qualified event a single pulse
   a_r5_fire_single: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);
   // R5: an event only follows a cycle in which the input was bad
   a_r5_fire_after_bad: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> $past(bad && !clear && tick));
endmodule

// File: rtl/bswap_timer.sv
module bswap_timer #(
   parameter int DEBOUNCE_TICKS = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   input  logic tick,
   output logic done
);
   localparam int DW = $clog2(DEBOUNCE_TICKS);
   localparam logic [DW-1:0] DLAST = DW'(DEBOUNCE_TICKS - 1);

   logic [DW-1:0] cnt;

   if (DEBOUNCE_TICKS < 2) begin : g_bad_deb
      $error("bswap_timer: DEBOUNCE_TICKS must be at least 2");
   end

   assign done = run && tick && (cnt == DLAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= '0;
      end else if (run && tick) begin
         cnt <= done ? '0 : cnt + 1'b1;
      end
   end

   // R2: the settling count never passes its last value
   a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= DLAST);
endmodule

// File: rtl/bswap_status.sv
module bswap_status (
   input  logic clk,
   input  logic rst_n,
   input  logic swap_evt,
   input  logic fail_wr,
   input  logic fail_wdata,
   input  logic por_wr,
   input  logic por_wdata,
   output logic soft_rst,
   output logic fail_flag,
   output logic por_flag
);
   assign soft_rst = por_wr && por_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail_flag <= 1'b0;
         por_flag  <= 1'b1;
      end else begin
         if (soft_rst)
            fail_flag <= 1'b0;
         else if (swap_evt)
            fail_flag <= 1'b1;
         else if (fail_wr && !fail_wdata)
            fail_flag <= 1'b0;

         if (soft_rst)
            por_flag <= 1'b1;
         else if (por_wr && !por_wdata)
            por_flag <= 1'b0;
      end
   end

   // R8: a swap set overrides a same-cycle software clear
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (swap_evt && !soft_rst) |=> fail_flag);
   // R8: writing 1 leaves the flag as it was
   a_r8_write_one_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_wr && fail_wdata && !swap_evt && !soft_rst) |=> (fail_flag == $past(fail_flag)));
   // R9: soft reset sets the power-on flag and drops the failure flag
   a_r9_soft_flags: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (por_flag && !fail_flag));
endmodule

// File: rtl/bswap_seq.sv
module bswap_seq
   import bswap_pkg::*;
#(
   parameter int QUAL_TICKS     = 32768,
   parameter int DEBOUNCE_TICKS = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic uv_low,
   input  logic det_high,
   input  logic rst_sense,
   input  logic meas_done,
   input  logic fail_wr,
   input  logic fail_wdata,
   input  logic por_wr,
   input  logic por_wdata,
   output logic chg_inhibit,
   output logic rst_pulldown,
   output logic meas_req,
   output logic restart,
   output logic fail_flag,
   output logic por_flag
);
   seq_state_t state;
   logic [NUM_SRC-1:0] src_bad;
   logic [NUM_SRC-1:0] fire;
   logic soft_rst;
   logic settle_done;
   logic live;
   logic parked;
   logic hold;

   assign src_bad[SRC_UV]  = uv_low;
   assign src_bad[SRC_DET] = det_high;
   assign live   = (state == ST_SETTLE) || (state == ST_MEASURE) || (state == ST_RUN);
   assign parked = (state == ST_SWAP_UV) || (state == ST_SWAP_DET);

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      bswap_qualify #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
         .clk   (clk),
         .rst_n (rst_n),
         .clear (soft_rst || parked),
         .tick  (tick),
         .bad   (src_bad[s]),
         .fire  (fire[s])
      );
   end

   bswap_timer #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (soft_rst || (state != ST_SETTLE)),
      .run   (state == ST_SETTLE),
      .tick  (tick),
      .done  (settle_done)
   );

   bswap_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .swap_evt   (|fire),
      .fail_wr    (fail_wr),
      .fail_wdata (fail_wdata),
      .por_wr     (por_wr),
      .por_wdata  (por_wdata),
      .soft_rst   (soft_rst),
      .fail_flag  (fail_flag),
      .por_flag   (por_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_SETTLE;
         restart <= 1'b0;
         hold    <= 1'b0;
      end else begin
         restart <= 1'b0;
         if (soft_rst) begin
            state <= ST_SETTLE;
            hold  <= 1'b0;
         end else if (live && fire[SRC_UV]) begin
            state <= ST_SWAP_UV;
            hold  <= 1'b0;
         end else if (live && fire[SRC_DET]) begin
            state <= ST_SWAP_DET;
            hold  <= 1'b0;
         end else begin
            case (state)
               ST_SETTLE: begin
                  if (!rst_sense) hold <= 1'b1;
                  if (settle_done) state <= ST_MEASURE;
               end
               ST_MEASURE: begin
                  if (meas_done) begin
                     state <= ST_RUN;
                     hold  <= 1'b0;
                  end else if (!rst_sense) begin
                     hold <= 1'b1;
                  end
               end
               ST_RUN: ;
               ST_SWAP_UV: begin
                  if (!uv_low) begin
                     state   <= ST_SETTLE;
                     restart <= 1'b1;
                  end
               end
               ST_SWAP_DET: begin
                  if (!det_high) begin
                     state   <= ST_SETTLE;
                     restart <= 1'b1;
                  end
               end
               default: state <= ST_SETTLE;
            endcase
         end
      end
   end

   assign meas_req     = (state == ST_MEASURE);
   assign chg_inhibit  = (state == ST_MEASURE);
   assign rst_pulldown = hold;

   // R2: without a tick the settling phase cannot end
   a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SETTLE && !tick && !soft_rst && fire == '0) |=> (state == ST_SETTLE));
   // R3: an accepted end of measurement releases everything
   a_r3_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MEASURE && meas_done && fire == '0 && !soft_rst) |=> (state == ST_RUN && !rst_pulldown));
   // R4: the reset pull-down only exists during start-up
   a_r4_pulldown_scope: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulldown |-> (state == ST_SETTLE || state == ST_MEASURE));
   // R6: a restart pulse only follows a parked swap state
   a_r6_restart_origin: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> (state == ST_SETTLE && $past(state == ST_SWAP_UV || state == ST_SWAP_DET)));
   // R6: restart is a single-cycle pulse
   a_r6_restart_single: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !restart);
   // R10: a qualified supply swap beats a same-cycle end of measurement
   a_r10_swap_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MEASURE && fire[SRC_UV] && !soft_rst) |=> (state == ST_SWAP_UV));
endmodule

// File: tb/tb_bswap_seq.sv
module tb_bswap_seq;
   localparam int Q = 16;
   localparam int D = 8;
   localparam int VN = 6;
   // vector table: source (0 = supply, 1 = detect), bad length in edges, swap expected
   localparam int VSRC [VN] = '{0, 0, 0, 0, 1, 1};
   localparam int VLEN [VN] = '{1, Q-1, Q, Q+5, Q-1, Q};
   localparam int VEXP [VN] = '{0, 0, 1, 1, 0, 1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1;
   logic uv_low = 1'b0, det_high = 1'b0, meas_done = 1'b0;
   logic fail_wr = 1'b0, fail_wdata = 1'b0, por_wr = 1'b0, por_wdata = 1'b0;
   logic ext_low = 1'b0;
   logic rst_line;
   logic chg_inhibit, rst_pulldown, meas_req, restart, fail_flag, por_flag;
   int n_chk = 0;
   int n_fail = 0;
   int n_restart = 0;

   always #4 clk = ~clk;
   assign rst_line = ~(ext_low | rst_pulldown);

   bswap_seq #(.QUAL_TICKS(Q), .DEBOUNCE_TICKS(D)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .uv_low(uv_low), .det_high(det_high),
      .rst_sense(rst_line), .meas_done(meas_done), .fail_wr(fail_wr),
      .fail_wdata(fail_wdata), .por_wr(por_wr), .por_wdata(por_wdata),
      .chg_inhibit(chg_inhibit), .rst_pulldown(rst_pulldown), .meas_req(meas_req),
      .restart(restart), .fail_flag(fail_flag), .por_flag(por_flag));

   always @(posedge clk) if (restart) n_restart <= n_restart + 1;

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic bring_to_run();
      for (int i = 0; i < 200 && !meas_req; i++) step(1);
      meas_done = 1'b1; step(1); meas_done = 1'b0;
      fail_wr = 1'b1; fail_wdata = 1'b0; step(1); fail_wr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      int rc;
      step(3);
      // R1 reset state
      chk("R1", "por_flag", por_flag, 1);
      chk("R1", "fail_flag", fail_flag, 0);
      chk("R1", "meas_req", meas_req, 0);
      chk("R1", "chg_inhibit", chg_inhibit, 0);
      chk("R1", "restart", restart, 0);
      chk("R1", "rst_pulldown", rst_pulldown, 0);
      rst_n = 1'b1;
      step(D-1);
      chk("R2", "meas_req before settle end", meas_req, 0);
      step(1);
      chk("R2", "meas_req at settle end", meas_req, 1);
      chk("R3", "chg_inhibit in measurement", chg_inhibit, 1);
      chk("R4", "no pulldown with line high", rst_pulldown, 0);
      step(4);
      chk("R3", "meas_req held", meas_req, 1);
      meas_done = 1'b1; step(1); meas_done = 1'b0;
      chk("R3", "meas_req after done", meas_req, 0);
      chk("R3", "chg_inhibit after done", chg_inhibit, 0);
      rc = n_restart;
      meas_done = 1'b1; step(1); meas_done = 1'b0; step(2);
      chk("R3", "stray done meas_req", meas_req, 0);
      chk("R3", "stray done restarts", n_restart - rc, 0);

      // R5 R7 table of dip lengths
      for (int v = 0; v < VN; v++) begin
         rc = n_restart;
         if (VSRC[v] == 0) uv_low = 1'b1; else det_high = 1'b1;
         step(VLEN[v]);
         uv_low = 1'b0; det_high = 1'b0;
         step(3);
         chk(VSRC[v] == 0 ? "R5" : "R7", $sformatf("vector %0d fail_flag", v), fail_flag, VEXP[v]);
         chk(VSRC[v] == 0 ? "R6" : "R7", $sformatf("vector %0d restarts", v), n_restart - rc, VEXP[v]);
         if (VEXP[v] != 0) bring_to_run();
         else chk("R5", $sformatf("vector %0d no interruption", v), meas_req, 0);
      end

      // R5 two sub-window dips split by one good cycle
      uv_low = 1'b1; step(Q-1); uv_low = 1'b0; step(1);
      uv_low = 1'b1; step(Q-1); uv_low = 1'b0; step(3);
      chk("R5", "split dips fail_flag", fail_flag, 0);

      // R6 exact restart pulse
      uv_low = 1'b1; step(Q+2);
      chk("R5", "swap parks, no measurement", meas_req, 0);
      chk("R6", "no restart while low", restart, 0);
      uv_low = 1'b0; step(1);
      chk("R6", "restart pulse", restart, 1);
      step(1);
      chk("R6", "restart one cycle", restart, 0);
      step(D-2);
      chk("R6", "resettle not yet done", meas_req, 0);
      step(1);
      chk("R6", "resettle measurement", meas_req, 1);
      bring_to_run();

      // R8 flag writes
      fail_wr = 1'b1; fail_wdata = 1'b1; step(1); fail_wr = 1'b0;
      chk("R8", "write 1 on clear flag", fail_flag, 0);
      // R8 coincident set and clear
      uv_low = 1'b1; step(Q);
      fail_wr = 1'b1; fail_wdata = 1'b0; step(1); fail_wr = 1'b0;
      chk("R8", "set beats clear", fail_flag, 1);
      fail_wr = 1'b1; fail_wdata = 1'b1; step(1); fail_wr = 1'b0;
      chk("R8", "write 1 on set flag", fail_flag, 1);
      uv_low = 1'b0; step(2);

      // R9 soft reset, with ticks stopped
      rc = n_restart;
      por_wr = 1'b1; por_wdata = 1'b1; tick = 1'b0; step(1); por_wr = 1'b0;
      chk("R9", "soft reset por_flag", por_flag, 1);
      chk("R9", "soft reset fail_flag", fail_flag, 0);
      step(3*D);
      chk("R2", "no ticks no measurement", meas_req, 0);
      chk("R9", "soft reset no restart", n_restart - rc, 0);
      tick = 1'b1; step(D-1);
      chk("R2", "ticks resume not yet", meas_req, 0);
      step(1);
      chk("R2", "ticks resume measurement", meas_req, 1);
      por_wr = 1'b1; por_wdata = 1'b0; step(1); por_wr = 1'b0;
      chk("R9", "write 0 clears por_flag", por_flag, 0);

      // R10 swap and end of measurement in one cycle
      uv_low = 1'b1; step(Q);
      meas_done = 1'b1; step(1); meas_done = 1'b0;
      chk("R10", "meas_req dropped", meas_req, 0);
      chk("R10", "fail_flag set", fail_flag, 1);
      uv_low = 1'b0; step(1);
      chk("R10", "restart proves swap state", restart, 1);
      bring_to_run();

      // R4 start-up with platform reset already low
      rst_n = 1'b0; ext_low = 1'b1; step(2);
      chk("R4", "no pulldown in reset", rst_pulldown, 0);
      rst_n = 1'b1; step(1);
      chk("R4", "pulldown taken", rst_pulldown, 1);
      ext_low = 1'b0; step(D+2);
      chk("R4", "pulldown held in measurement", rst_pulldown, 1);
      chk("R4", "line still low", rst_line, 0);
      meas_done = 1'b1; step(1); meas_done = 1'b0;
      chk("R4", "pulldown released", rst_pulldown, 0);
      chk("R4", "line released", rst_line, 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule